// File: doc/BRIEF.md
# PCI Host Bridge Window Register File

This block is the control register file of a PCI host bridge. It answers a simple single-beat register port that carries an address, a read/write strobe, a byte count and 64-bit data. It claims only a 4 KiB region whose base is a parameter. Any request outside that region is flagged for another target and left untouched. Inside the region, each register takes one 64-byte slot, so the register index is the region offset shifted right by six.

The file holds four groups of window registers and a bridge control word. For each of the four DMA windows there is a window base, a window mask and a translated base. All of them, together with the control word, drive output buses to a companion address translator. A few maintenance and status slots read as zero: an error status slot, an error mask slot and a translation-invalidate-all slot. Every other slot inside the region answers with an error response. This covers the slots reserved for latency, error injection, single-entry invalidate and performance monitoring, as well as any index with no meaning.

One access is handled at a time. A request is accepted only while `req_ready` is high. The reply arrives a fixed, parameterised number of cycles after acceptance, as a one-cycle `rsp_valid` pulse with a separate error flag.

Top module: `pcib_regfile`

## Requirements
- R1: After synchronous reset every window base, window mask and translated base register is zero, the control word is 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in the field at bits 39:36), `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request whose address bits above bit 11 differ from those of `BASE_ADDR` raises `req_fwd` in the same cycle, is not accepted, produces no response and changes no register.
- R3: The register index is address bits 11:6, and address bits 5:0 are ignored. The map is: control word at index 0, error status at 1, error mask at 2, invalidate-all at 3, window base w at 8+w, window mask w at 12+w, translated base w at 16+w.
- R4: An access with `req_bytes` other than 8 gets an error response and changes no register.
- R5: A legal write to the control word or to a window register stores all 64 bits. A later read of that register returns them. The new value appears on `ctrl_o` or on slice w of the matching window bus from the cycle after the accepting edge.
- R6: The error status slot and the invalidate-all slot read as zero without error. Writes to them complete without error and have no effect.
- R7: The error mask slot reads as zero without error. A write to it gets an error response and has no effect.
- R8: Any other index inside the region gets an error response on both reads and writes and has no effect.
- R9: The response is a single-cycle `rsp_valid` pulse that is visible after the LATENCY-th rising edge following the accepting edge.
- R10: When `rsp_err` is 1, `rsp_rdata` is zero. A successful write also returns zero data.
- R11: `req_ready` is low from the accepting edge until the response cycle. A request presented while `req_ready` is low is neither accepted nor answered and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | 4 | Access size in bytes (8 is the only legal value) |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Block can take a request |
| req_fwd | output | 1 | Request lies outside the claimed region |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 64 | Read data |
| ctrl_o | output | 64 | Bridge control word |
| win_base_o | output | 4*64 | Window base registers, window w in bits 64w+63:64w |
| win_mask_o | output | 4*64 | Window mask registers |
| win_xlat_o | output | 4*64 | Translated base registers |

## Verification
Directed accesses first walk every implemented register with distinct data patterns. This shows that each index reaches its own storage and its own output slice. It also shows that the ignored low address bits are really ignored. Further directed cases cover the slots that read as zero, the write-rejecting error mask slot, unimplemented indices, wrong access sizes and out-of-region addresses. Each of these separates a silent discard from an error response, and a claimed access from a forwarded one. A request held on the port during a busy window shows that hold-off really blocks acceptance. A seeded random mix of indices, sizes, low address bits and data then checks every reply and every output bus against a bench model.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

    localparam int DATA_W      = 64;
    localparam int N_WIN       = 4;
    localparam int WIN_W       = (N_WIN > 1) ? $clog2(N_WIN) : 1;
    localparam int REGION_BITS = 12;
    localparam int SLOT_BITS   = 6;
    localparam int IDX_W       = REGION_BITS - SLOT_BITS;
    localparam int FULL_BYTES  = DATA_W / 8;

    // register slot map (index = offset >> SLOT_BITS)
    localparam int IDX_CTRL    = 0;
    localparam int IDX_ERRSTAT = 1;
    localparam int IDX_ERRMASK = 2;
    localparam int IDX_INVALL  = 3;
    localparam int IDX_BASE0   = 8;
    localparam int IDX_MASK0   = IDX_BASE0 + N_WIN;
    localparam int IDX_XLAT0   = IDX_MASK0 + N_WIN;

    // control word reset pattern
    localparam int CTRL_BIT_A   = 20;
    localparam int CTRL_BIT_B   = 32;
    localparam int CTRL_FLD_LSB = 36;
    localparam logic [DATA_W-1:0] CTRL_RST =
        (DATA_W'(1) << CTRL_BIT_A) | (DATA_W'(1) << CTRL_BIT_B) |
        (DATA_W'(2) << CTRL_FLD_LSB);

    typedef enum logic [2:0] {
        RK_CTRL,
        RK_BASE,
        RK_MASK,
        RK_XLAT,
        RK_ZERO,     // reads zero, write discarded
        RK_ZERO_RO,  // reads zero, write is an error
        RK_NONE      // unimplemented or undefined
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [WIN_W-1:0] win;
    } reg_sel_t;

    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    function automatic reg_sel_t decode_index(input logic [IDX_W-1:0] idx);
        reg_sel_t s;
        int       i;
        i      = int'(idx);
        s.kind = RK_NONE;
        s.win  = '0;
        if (i == IDX_CTRL) begin
            s.kind = RK_CTRL;
        end else if (i == IDX_ERRSTAT || i == IDX_INVALL) begin
            s.kind = RK_ZERO;
        end else if (i == IDX_ERRMASK) begin
            s.kind = RK_ZERO_RO;
        end else if (i >= IDX_BASE0 && i < IDX_BASE0 + N_WIN) begin
            s.kind = RK_BASE;
            s.win  = WIN_W'(i - IDX_BASE0);
        end else if (i >= IDX_MASK0 && i < IDX_MASK0 + N_WIN) begin
            s.kind = RK_MASK;
            s.win  = WIN_W'(i - IDX_MASK0);
        end else if (i >= IDX_XLAT0 && i < IDX_XLAT0 + N_WIN) begin
            s.kind = RK_XLAT;
            s.win  = WIN_W'(i - IDX_XLAT0);
        end
        return s;
    endfunction

endpackage

// File: rtl/pcib_decode.sv
module pcib_decode
    import pcib_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_bytes,
    input  logic              busy,
    output logic              accept,
    output logic              fwd,
    output logic              do_write,
    output logic              bad,
    output reg_sel_t          sel
);

    logic hit;
    logic size_bad;

    assign hit      = (req_addr[ADDR_W-1:REGION_BITS] == BASE_ADDR[ADDR_W-1:REGION_BITS]);
    assign sel      = decode_index(req_addr[REGION_BITS-1:SLOT_BITS]);
    assign size_bad = (req_bytes != 4'(FULL_BYTES));

    always_comb begin
        bad = size_bad;
        case (sel.kind)
            RK_NONE:    bad = 1'b1;
            RK_ZERO_RO: if (req_write) bad = 1'b1;
            default:    ;
        endcase
    end

    assign accept   = req_valid & hit & ~busy;
    assign fwd      = req_valid & ~hit;
    assign do_write = accept & req_write & ~bad;

endmodule

// File: rtl/pcib_regs.sv
module pcib_regs
    import pcib_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  reg_sel_t                sel,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rd_data,
    output logic [DATA_W-1:0]       ctrl_q,
    output logic [N_WIN*DATA_W-1:0] base_flat,
    output logic [N_WIN*DATA_W-1:0] mask_flat,
    output logic [N_WIN*DATA_W-1:0] xlat_flat
);

    logic [DATA_W-1:0] base_a [N_WIN];
    logic [DATA_W-1:0] mask_a [N_WIN];
    logic [DATA_W-1:0] xlat_a [N_WIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en && sel.kind == RK_CTRL) begin
            ctrl_q <= wdata;
        end
    end

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        logic [DATA_W-1:0] base_r;
        logic [DATA_W-1:0] mask_r;
        logic [DATA_W-1:0] xlat_r;
        logic              pick;

        assign pick = wr_en && (sel.win == WIN_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_r <= '0;
                mask_r <= '0;
                xlat_r <= '0;
            end else if (pick) begin
                case (sel.kind)
                    RK_BASE: base_r <= wdata;
                    RK_MASK: mask_r <= wdata;
                    RK_XLAT: xlat_r <= wdata;
                    default: ;
                endcase
            end
        end

        assign base_a[w] = base_r;
        assign mask_a[w] = mask_r;
        assign xlat_a[w] = xlat_r;
        assign base_flat[w*DATA_W +: DATA_W] = base_r;
        assign mask_flat[w*DATA_W +: DATA_W] = mask_r;
        assign xlat_flat[w*DATA_W +: DATA_W] = xlat_r;
    end

    always_comb begin
        case (sel.kind)
            RK_CTRL: rd_data = ctrl_q;
            RK_BASE: rd_data = base_a[sel.win];
            RK_MASK: rd_data = mask_a[sel.win];
            RK_XLAT: rd_data = xlat_a[sel.win];
            default: rd_data = '0;
        endcase
    end

    AST_CTRL_RESET_PATTERN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ctrl_q == CTRL_RST); // R1

    AST_CTRL_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q)); // R4

    AST_BASE0_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(base_a[0])); // R8

endmodule

// File: rtl/pcib_resp.sv
module pcib_resp
    import pcib_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  rsp_t              rsp_in,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    logic [CNT_W-1:0] cnt;
    rsp_t             held;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            rsp_valid <= 1'b0;
            held      <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(LATENCY - 1);
                held <= rsp_in;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy      <= 1'b0;
                    rsp_valid <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    assign rsp_err   = rsp_valid & held.err;
    assign rsp_rdata = rsp_valid ? held.rdata : '0;

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9

    AST_BUSY_ENDS_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid); // R9

    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> rsp_rdata == '0); // R10

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !accept); // R11

endmodule

// File: rtl/pcib_regfile.sv
module pcib_regfile
    import pcib_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0008_0000,
    parameter int                LATENCY   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [3:0]              req_bytes,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_ready,
    output logic                    req_fwd,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [DATA_W-1:0]       ctrl_o,
    output logic [N_WIN*DATA_W-1:0] win_base_o,
    output logic [N_WIN*DATA_W-1:0] win_mask_o,
    output logic [N_WIN*DATA_W-1:0] win_xlat_o
);

    logic              busy;
    logic              accept;
    logic              do_write;
    logic              bad;
    reg_sel_t          sel;
    logic [DATA_W-1:0] rd_data;
    rsp_t              rsp_in;

    pcib_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_bytes (req_bytes),
        .busy      (busy),
        .accept    (accept),
        .fwd       (req_fwd),
        .do_write  (do_write),
        .bad       (bad),
        .sel       (sel)
    );

    pcib_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (do_write),
        .sel       (sel),
        .wdata     (req_wdata),
        .rd_data   (rd_data),
        .ctrl_q    (ctrl_o),
        .base_flat (win_base_o),
        .mask_flat (win_mask_o),
        .xlat_flat (win_xlat_o)
    );

    always_comb begin
        rsp_in.err   = bad;
        rsp_in.rdata = (bad || req_write) ? '0 : rd_data;
    end

    pcib_resp #(
        .LATENCY (LATENCY)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .rsp_in    (rsp_in),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    assign req_ready = ~busy;

    AST_FWD_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        req_fwd |=> $stable(ctrl_o) && $stable(win_base_o)); // R2

    AST_READY_LOW_UNTIL_RSP: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> rsp_valid); // R11

endmodule

// File: tb/pcib_regfile_test.sv
`timescale 1ns/1ps
module pcib_regfile_test;

    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'h0008_0000;
    localparam int          LAT  = 3;
    localparam int          NW   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr  = '0;
    logic [3:0]       req_bytes = 4'd8;
    logic [63:0]      req_wdata = '0;
    logic             req_ready, req_fwd, rsp_valid, rsp_err;
    logic [63:0]      rsp_rdata, ctrl_o;
    logic [NW*64-1:0] win_base_o, win_mask_o, win_xlat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] m_ctrl;
    logic [63:0] m_base [NW];
    logic [63:0] m_mask [NW];
    logic [63:0] m_xlat [NW];

    pcib_regfile #(.ADDR_W(AW), .BASE_ADDR(BASE), .LATENCY(LAT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_fwd(req_fwd), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ctrl_o(ctrl_o),
        .win_base_o(win_base_o), .win_mask_o(win_mask_o), .win_xlat_o(win_xlat_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmp_state(input string req);
        chk(ctrl_o === m_ctrl, {req, " ctrl_o"}, ctrl_o, m_ctrl);
        for (int w = 0; w < NW; w++) begin
            chk(win_base_o[w*64 +: 64] === m_base[w], {req, " base bus"}, win_base_o[w*64 +: 64], m_base[w]);
            chk(win_mask_o[w*64 +: 64] === m_mask[w], {req, " mask bus"}, win_mask_o[w*64 +: 64], m_mask[w]);
            chk(win_xlat_o[w*64 +: 64] === m_xlat[w], {req, " xlat bus"}, win_xlat_o[w*64 +: 64], m_xlat[w]);
        end
    endtask

    // bench model of one in-region access
    task automatic predict(input bit wr, input int idx, input int nb, input logic [63:0] wd,
                           output bit e, output logic [63:0] rd);
        e  = 1'b0;
        rd = '0;
        if (nb != 8) begin
            e = 1'b1;
        end else if (idx == 0) begin
            if (wr) m_ctrl = wd; else rd = m_ctrl;
        end else if (idx == 1 || idx == 3) begin
            rd = '0;
        end else if (idx == 2) begin
            if (wr) e = 1'b1;
        end else if (idx >= 8 && idx < 8 + NW) begin
            if (wr) m_base[idx-8] = wd; else rd = m_base[idx-8];
        end else if (idx >= 12 && idx < 12 + NW) begin
            if (wr) m_mask[idx-12] = wd; else rd = m_mask[idx-12];
        end else if (idx >= 16 && idx < 16 + NW) begin
            if (wr) m_xlat[idx-16] = wd; else rd = m_xlat[idx-16];
        end else begin
            e = 1'b1;
        end
    endtask

    // called at a negedge with req_ready high
    task automatic access(input bit wr, input int idx, input logic [5:0] low, input int nb,
                          input logic [63:0] wd, input bit rogue, input string req);
        bit          e;
        logic [63:0] rd;
        int          n;
        predict(wr, idx, nb, wd, e, rd);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = BASE + 32'(idx * 64) + 32'(low);
        req_bytes = 4'(nb);
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        chk(req_ready == 1'b0, "R11 ready low after accept", 64'(req_ready), 64'd0);
        if (rogue) begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = BASE;
            req_bytes = 4'd8;
            req_wdata = 64'hDEAD_BEEF_0BAD_F00D;
        end
        while (!rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
            if (rogue && n == LAT - 1) req_valid = 1'b0;
        end
        chk(n == LAT, "R9 latency", 64'(n), 64'(LAT));
        chk(rsp_err === e, {req, " err flag"}, 64'(rsp_err), 64'(e));
        chk(rsp_rdata === rd, {req, " read data"}, rsp_rdata, rd);
        if (e) chk(rsp_rdata === '0, "R10 error data zero", rsp_rdata, 64'd0);
        cmp_state(req);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 single pulse", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R11 ready after response", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = 64'h0000_0021_0010_0000;
        for (int w = 0; w < NW; w++) begin
            m_base[w] = '0; m_mask[w] = '0; m_xlat[w] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready at reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 no response at reset", 64'(rsp_valid), 64'd0);
        cmp_state("R1");
        access(1'b0, 0, 6'd0, 8, '0, 1'b0, "R1 control read");

        // R5 walk all implemented registers
        for (int w = 0; w < NW; w++) begin
            access(1'b1, 8 + w,  6'd0, 8, {32'hB0B0_0000 + 32'(w), 32'h1111_0000 + 32'(w)}, 1'b0, "R5 write base");
            access(1'b1, 12 + w, 6'd0, 8, {32'h3A5C_0000 + 32'(w), 32'hFFF0_0000}, 1'b0, "R5 write mask");
            access(1'b1, 16 + w, 6'd0, 8, {32'h7700_0000 + 32'(w), 32'h0000_ABCD}, 1'b0, "R5 write xlat");
        end
        for (int i = 8; i < 20; i++) access(1'b0, i, 6'd0, 8, '0, 1'b0, "R5 read back");
        access(1'b1, 0, 6'd0, 8, 64'hFEDC_BA98_7654_3210, 1'b0, "R5 write control");

        // R3 low address bits ignored
        access(1'b1, 0, 6'h3F, 8, 64'h0123_4567_89AB_CDEF, 1'b0, "R3 offset low bits write");
        access(1'b0, 0, 6'h21, 8, '0, 1'b0, "R3 offset low bits read");
        access(1'b0, 9, 6'h08, 8, '0, 1'b0, "R3 base1 low bits read");

        // R4 wrong sizes
        access(1'b1, 0, 6'd0, 4, 64'h5555_5555_5555_5555, 1'b0, "R4 short write");
        access(1'b0, 8, 6'd0, 1, '0, 1'b0, "R4 short read");

        // R6 zero slots, R7 error mask
        access(1'b1, 1, 6'd0, 8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R6 errstat write");
        access(1'b0, 1, 6'd0, 8, '0, 1'b0, "R6 errstat read");
        access(1'b1, 3, 6'd0, 8, 64'h1234, 1'b0, "R6 invall write");
        access(1'b0, 3, 6'd0, 8, '0, 1'b0, "R6 invall read");
        access(1'b0, 2, 6'd0, 8, '0, 1'b0, "R7 errmask read");
        access(1'b1, 2, 6'd0, 8, 64'hAAAA, 1'b0, "R7 errmask write");

        // R8 unimplemented and undefined slots
        access(1'b0, 24, 6'd0, 8, '0, 1'b0, "R8 unimplemented read");
        access(1'b1, 29, 6'd0, 8, 64'h99, 1'b0, "R8 unimplemented write");
        access(1'b1, 63, 6'd0, 8, 64'h77, 1'b0, "R8 top index write");
        access(1'b0, 5, 6'd0, 8, '0, 1'b0, "R8 gap index read");

        // R2 out-of-region request
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = BASE + 32'h1000;
        req_bytes = 4'd8;
        req_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
        #1;
        chk(req_fwd == 1'b1, "R2 forward flag", 64'(req_fwd), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b1, "R2 not accepted", 64'(req_ready), 64'd1);
        for (int k = 0; k < LAT + 2; k++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R2 no response", 64'(rsp_valid), 64'd0);
        end
        cmp_state("R2");
        req_addr = BASE - 32'd64;
        req_valid = 1'b1;
        #1;
        chk(req_fwd == 1'b1, "R2 forward below base", 64'(req_fwd), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        cmp_state("R2");

        // R11 request held during busy window is ignored
        access(1'b0, 10, 6'd0, 8, '0, 1'b1, "R11 rogue during busy");
        access(1'b0, 0, 6'd0, 8, '0, 1'b0, "R11 control unchanged");

        // random mix
        for (int t = 0; t < 400; t++) begin
            int          idx;
            int          nb;
            bit          wr;
            logic [5:0]  low;
            logic [63:0] wd;
            if ($urandom % 4 == 0) idx = int'($urandom % 64);
            else idx = int'($urandom % 20);
            nb  = ($urandom % 8 == 0) ? int'($urandom % 8) : 8;
            wr  = 1'($urandom);
            low = 6'($urandom);
            wd  = {$urandom, $urandom};
            access(wr, idx, low, nb, wd, 1'b0, "R5 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule